// File: doc/BRIEF.md
# Self-Stalling Functional Unit Pipeline

This block is one functional unit of an execute stage. It takes one instruction token at a time on an insert port and carries it through a chain of stages. The length of the chain is the unit's operation latency. The operation latency and the minimum spacing between insertions are fixed for the unit, not set per operation. When a token reaches the last stage, the unit presents it on a valid/accept output and holds it there until the commit side takes it. While that token waits, every stage behind it freezes. Empty slots move through the chain as bubbles and never hold anything up.

Each candidate instruction has to pass two checks before the unit takes it. The first is a per-class capability bitmap. The second is a short table of timing entries, each of which compares the masked instruction word with a match value. The lowest-numbered entry that matches decides the timing. That entry can forbid the instruction from issuing in this unit, restrict the allowed classes further, or add extra cycles that the token waits in the last stage before it is offered to commit. An instruction that matches no entry gets default timing.

Top module: `stall_fu_pipe`

## Requirements
- R1: After reset the unit is empty: `out_valid` is 0 and `can_insert` is 1.
- R2: A token taken in cycle c with no extra delay, while commit accepts, appears on `out_valid` with its tag in cycle c+OP_LAT (3 by default). A token's count in flight never exceeds OP_LAT.
- R3: After a take in cycle c, `can_insert` stays low and no take happens in cycles c+1 to c+ISSUE_LAT-1 (ISSUE_LAT is 2 by default). Insertion is allowed again in cycle c+ISSUE_LAT.
- R4: While `out_valid` is high and `out_accept` is low, the token stays presented and `out_tag` does not change. Tokens leave in the order they were taken.
- R5: Insertion is refused while the first stage holds a token and the chain cannot advance in that cycle.
- R6: A class whose bit in CAP_MASK is 0 is never taken, and no output results. The default CAP_MASK is 8'h3B, which allows classes 0, 1, 3, 4 and 5.
- R7: Timing entries are tried from index 0 upward and the first match wins. Entry i matches when (insn & mask_i) == match_i. The default entries are: 0 = mask F000 / match A000, 1 = mask F000 / match B000, 2 = mask 00FF / match 0055.
- R8: A matching entry with its suppress bit set blocks the take. Only entry 0 suppresses by default.
- R9: A matching entry's extra count delays presentation to cycle c+OP_LAT+extra. By default entry 1 adds 2 cycles and the other entries add 0.
- R10: A matching entry's class mask must also allow the class. By default entry 2 allows class 0 only, and the other entries allow every class.
- R11: A bubble between two tokens does not stall the chain. With commit ready, tokens taken in cycles c and c+2 appear in cycles c+3 and c+5, and `out_valid` is low in cycle c+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Candidate instruction present |
| in_class | input | CLS_W (3) | Operation class of the candidate |
| in_insn | input | INSN_W (16) | Instruction word used by the timing table |
| in_tag | input | TAG_W (8) | Token identifier carried to the output |
| can_insert | output | 1 | Unit can take a token this cycle (issue spacing and stage 0 room) |
| in_taken | output | 1 | The candidate is taken this cycle |
| out_valid | output | 1 | Completed token presented to commit |
| out_tag | output | TAG_W (8) | Identifier of the presented token |
| out_accept | input | 1 | Commit takes the presented token |

## Verification
The bench checks that a stalled tail freezes the whole chain. A design that let upstream stages keep moving would lose or reorder the token queued behind it, or would accept a new insertion into a first stage that is still occupied. It checks the order of the timing entries on words that match two entries at once. With the wrong order, a suppressed word would issue, or a word that should get extra delay would be rejected on its class. It checks the exact output cycle for zero and nonzero extra delay and across a bubble, which catches an off-by-one in the tail counter or a bubble that stalls the chain. It also checks that `can_insert` drops for exactly the issue interval.

// File: rtl/fu_pipe_pkg.sv
package fu_pipe_pkg;
  localparam int EXTRA_W = 4;
  typedef logic [EXTRA_W-1:0] extra_t;
  typedef struct packed {
    logic   suppress;
    extra_t extra;
  } tm_result_t;
endpackage

// File: rtl/fu_timing_match.sv
module fu_timing_match
  import fu_pipe_pkg::*;
#(
  parameter int INSN_W   = 16,
  parameter int N_CLS    = 8,
  parameter int CLS_W    = 3,
  parameter int N_TIMING = 3,
  parameter logic [N_TIMING*INSN_W-1:0]  T_MASK     = '0,
  parameter logic [N_TIMING*INSN_W-1:0]  T_MATCH    = '0,
  parameter logic [N_TIMING-1:0]         T_SUPPRESS = '0,
  parameter logic [N_TIMING*EXTRA_W-1:0] T_EXTRA    = '0,
  parameter logic [N_TIMING*N_CLS-1:0]   T_CLS      = '1
) (
  input  logic [INSN_W-1:0] insn,
  input  logic [CLS_W-1:0]  cls,
  output tm_result_t        res,
  output logic              cls_ok
);
  // Scan from the top index down so that the lowest matching entry wins.
  always_comb begin
    res    = '0;
    cls_ok = 1'b1;
    for (int i = N_TIMING - 1; i >= 0; i--) begin
      if ((insn & T_MASK[i*INSN_W +: INSN_W]) == T_MATCH[i*INSN_W +: INSN_W]) begin
        res.suppress = T_SUPPRESS[i];
        res.extra    = T_EXTRA[i*EXTRA_W +: EXTRA_W];
        cls_ok       = T_CLS[i*N_CLS + int'(cls)];
      end
    end
  end
endmodule

// File: rtl/fu_issue_gate.sv
module fu_issue_gate #(
  parameter int ISSUE_LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  output logic gap_ok
);
  localparam int CW = (ISSUE_LAT < 2) ? 1 : $clog2(ISSUE_LAT + 1);
  logic [CW-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (rst)                wait_q <= '0;
    else if (take)          wait_q <= CW'(ISSUE_LAT - 1);
    else if (wait_q != '0)  wait_q <= wait_q - 1'b1;
  end

  assign gap_ok = (wait_q == '0);
endmodule

// File: rtl/fu_stage_chain.sv
module fu_stage_chain
  import fu_pipe_pkg::*;
#(
  parameter int OP_LAT = 3,
  parameter int TAG_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  input  extra_t           push_extra,
  input  logic             out_accept,
  output logic             s0_busy,
  output logic             move,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_tag
);
  localparam int LAST = OP_LAT - 1;

  logic [OP_LAT-1:0] v_q;
  logic [TAG_W-1:0]  tag_q [OP_LAT];
  extra_t            ex_q  [OP_LAT];
  extra_t            tail_wait_q;

  logic [OP_LAT-1:0] v_in;
  logic [TAG_W-1:0]  tag_in [OP_LAT];
  extra_t            ex_in  [OP_LAT];

  // Input of each stage: the new token for stage 0, the previous stage otherwise.
  always_comb begin
    v_in[0]   = push;
    tag_in[0] = push_tag;
    ex_in[0]  = push ? push_extra : '0;
    for (int i = 1; i < OP_LAT; i++) begin
      v_in[i]   = v_q[i-1];
      tag_in[i] = tag_q[i-1];
      ex_in[i]  = ex_q[i-1];
    end
  end

  assign out_valid = v_q[LAST] && (tail_wait_q == '0);
  assign move      = !v_q[LAST] || (out_valid && out_accept);
  assign s0_busy   = v_q[0];
  assign out_tag   = tag_q[LAST];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q         <= '0;
      tail_wait_q <= '0;
      for (int i = 0; i < OP_LAT; i++) begin
        tag_q[i] <= '0;
        ex_q[i]  <= '0;
      end
    end else if (move) begin
      v_q         <= v_in;
      tail_wait_q <= ex_in[LAST];
      for (int i = 0; i < OP_LAT; i++) begin
        tag_q[i] <= tag_in[i];
        ex_q[i]  <= ex_in[i];
      end
    end else begin
      // Frozen chain: only an empty first stage may be filled.
      if (push) begin
        v_q[0]   <= 1'b1;
        tag_q[0] <= push_tag;
        ex_q[0]  <= push_extra;
      end
      if (tail_wait_q != '0) tail_wait_q <= tail_wait_q - 1'b1;
    end
  end
endmodule

// File: rtl/stall_fu_pipe.sv
module stall_fu_pipe
  import fu_pipe_pkg::*;
#(
  parameter int OP_LAT    = 3,
  parameter int ISSUE_LAT = 2,
  parameter int N_CLASSES = 8,
  parameter int INSN_W    = 16,
  parameter int TAG_W     = 8,
  parameter int N_TIMING  = 3,
  parameter logic [N_CLASSES-1:0] CAP_MASK = 8'h3B,
  parameter logic [N_TIMING*INSN_W-1:0]  T_MASK     = {16'h00FF, 16'hF000, 16'hF000},
  parameter logic [N_TIMING*INSN_W-1:0]  T_MATCH    = {16'h0055, 16'hB000, 16'hA000},
  parameter logic [N_TIMING-1:0]         T_SUPPRESS = 3'b001,
  parameter logic [N_TIMING*EXTRA_W-1:0] T_EXTRA    = {4'd0, 4'd2, 4'd0},
  parameter logic [N_TIMING*N_CLASSES-1:0] T_CLS    = {8'h01, 8'hFF, 8'hFF},
  localparam int CLS_W = $clog2(N_CLASSES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CLS_W-1:0]  in_class,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              can_insert,
  output logic              in_taken,
  output logic              out_valid,
  output logic [TAG_W-1:0]  out_tag,
  input  logic              out_accept
);
  tm_result_t tm_res;
  logic       tm_cls_ok;
  logic       gap_ok;
  logic       s0_busy;
  logic       move;
  logic       eligible;

  fu_timing_match #(
    .INSN_W(INSN_W), .N_CLS(N_CLASSES), .CLS_W(CLS_W), .N_TIMING(N_TIMING),
    .T_MASK(T_MASK), .T_MATCH(T_MATCH), .T_SUPPRESS(T_SUPPRESS),
    .T_EXTRA(T_EXTRA), .T_CLS(T_CLS)
  ) u_match (
    .insn(in_insn), .cls(in_class), .res(tm_res), .cls_ok(tm_cls_ok)
  );

  fu_issue_gate #(.ISSUE_LAT(ISSUE_LAT)) u_gate (
    .clk(clk), .rst(rst), .take(in_taken), .gap_ok(gap_ok)
  );

  fu_stage_chain #(.OP_LAT(OP_LAT), .TAG_W(TAG_W)) u_chain (
    .clk(clk), .rst(rst), .push(in_taken), .push_tag(in_tag),
    .push_extra(tm_res.extra), .out_accept(out_accept), .s0_busy(s0_busy),
    .move(move), .out_valid(out_valid), .out_tag(out_tag)
  );

  assign can_insert = gap_ok && (move || !s0_busy);
  assign eligible   = CAP_MASK[in_class] && tm_cls_ok && !tm_res.suppress;
  assign in_taken   = in_valid && can_insert && eligible;
endmodule

// File: rtl/fu_pipe_chk.sv
module fu_pipe_chk #(
  parameter int OP_LAT    = 3,
  parameter int ISSUE_LAT = 2,
  parameter int N_CLASSES = 8,
  parameter int TAG_W     = 8,
  parameter logic [N_CLASSES-1:0] CAP_MASK = '1,
  localparam int CLS_W = $clog2(N_CLASSES)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_taken,
  input logic [CLS_W-1:0] in_class,
  input logic             out_valid,
  input logic             out_accept,
  input logic [TAG_W-1:0] out_tag
);
  localparam int GW = $clog2(ISSUE_LAT + 2);
  localparam int FW = $clog2(OP_LAT + 2);

  logic [GW-1:0] since_q;
  logic [FW-1:0] inflight_q;

  always_ff @(posedge clk) begin
    if (rst)                        since_q <= GW'(ISSUE_LAT);
    else if (in_taken)              since_q <= GW'(1);
    else if (since_q < GW'(ISSUE_LAT)) since_q <= since_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) inflight_q <= '0;
    else     inflight_q <= inflight_q + FW'(in_taken) - FW'(out_valid && out_accept);
  end

  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  a_r2_bounded_occupancy: assert property (@(posedge clk) disable iff (rst)
    inflight_q <= FW'(OP_LAT));

  a_r2_no_phantom: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> inflight_q != '0);

  a_r3_issue_spacing: assert property (@(posedge clk) disable iff (rst)
    in_taken |-> since_q >= GW'(ISSUE_LAT));

  a_r4_tail_holds: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_accept) |=> (out_valid && $stable(out_tag)));

  a_r6_capable_class: assert property (@(posedge clk) disable iff (rst)
    in_taken |-> CAP_MASK[in_class]);
endmodule

bind stall_fu_pipe fu_pipe_chk #(
  .OP_LAT(OP_LAT), .ISSUE_LAT(ISSUE_LAT), .N_CLASSES(N_CLASSES),
  .TAG_W(TAG_W), .CAP_MASK(CAP_MASK)
) u_fu_pipe_chk (
  .clk(clk), .rst(rst), .in_taken(in_taken), .in_class(in_class),
  .out_valid(out_valid), .out_accept(out_accept), .out_tag(out_tag)
);

// File: tb/test_stall_fu_pipe.sv
module test_stall_fu_pipe;
  localparam int OP_LAT    = 3;
  localparam int ISSUE_LAT = 2;
  localparam int NV        = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [2:0] in_class = '0;
  logic [15:0] in_insn = '0;
  logic [7:0] in_tag = '0;
  logic       can_insert, in_taken, out_valid, out_accept;
  logic [7:0] out_tag;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stall_fu_pipe #(.OP_LAT(OP_LAT), .ISSUE_LAT(ISSUE_LAT)) i_stall_fu_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
    .in_insn(in_insn), .in_tag(in_tag), .can_insert(can_insert),
    .in_taken(in_taken), .out_valid(out_valid), .out_tag(out_tag),
    .out_accept(out_accept)
  );

  // {class[2:0], insn[15:0], taken, extra[3:0]}
  localparam logic [23:0] VEC [NV] = '{
    {3'd0, 16'h1234, 1'b1, 4'd0},  // no entry matches: default timing (R2)
    {3'd2, 16'h1234, 1'b0, 4'd0},  // class 2 not capable (R6)
    {3'd1, 16'hA777, 1'b0, 4'd0},  // entry 0 suppresses (R8)
    {3'd1, 16'hB0C3, 1'b1, 4'd2},  // entry 1 extra 2 (R9)
    {3'd1, 16'hB055, 1'b1, 4'd2},  // entries 1 and 2 match, 1 wins (R7)
    {3'd1, 16'h1055, 1'b0, 4'd0},  // entry 2 class mask rejects class 1 (R10)
    {3'd0, 16'h1055, 1'b1, 4'd0},  // entry 2 allows class 0 (R10)
    {3'd0, 16'hA055, 1'b0, 4'd0},  // entries 0 and 2 match, 0 wins (R7)
    {3'd6, 16'h0000, 1'b0, 4'd0},  // class 6 not capable (R6)
    {3'd5, 16'h0F00, 1'b1, 4'd0}   // capable class, default timing (R2)
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] c, input logic [15:0] w, input logic [7:0] t);
    in_valid = 1'b1; in_class = c; in_insn = w; in_tag = t;
    #1;
  endtask

  task automatic idle_step();
    @(negedge clk);
    in_valid = 1'b0;
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    out_accept = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(can_insert == 1'b1, "R1 can_insert", can_insert, 1);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      logic [2:0] vc; logic [15:0] vw; logic vt; logic [3:0] vx;
      int t0; int waited;
      {vc, vw, vt, vx} = VEC[k];
      @(negedge clk); #1;
      while (!can_insert) begin @(negedge clk); #1; end
      drive(vc, vw, 8'h10 + 8'(k));
      t0 = cyc;
      check(in_taken == vt, "R6 R7 R8 R10 take decision", in_taken, vt);
      idle_step();
      if (vt) begin
        waited = 0;
        while (!out_valid && waited < 20) begin @(negedge clk); #1; waited++; end
        check(cyc == t0 + OP_LAT + int'(vx), "R2 R9 arrival cycle", cyc - t0, OP_LAT + int'(vx));
        check(out_tag == 8'h10 + 8'(k), "R2 tag", out_tag, 8'h10 + 8'(k));
      end else begin
        logic seen = 1'b0;
        for (int j = 0; j < OP_LAT + 4; j++) begin
          @(negedge clk); #1;
          if (out_valid) seen = 1'b1;
        end
        check(!seen, "R6 R8 R10 nothing emerges", seen, 0);
      end
    end

    // Issue interval and bubble spacing (R3, R11)
    repeat (6) @(negedge clk);
    #1;
    begin
      int k0;
      drive(3'd0, 16'h1234, 8'hA1);
      k0 = cyc;
      check(in_taken == 1'b1, "R3 first take", in_taken, 1);
      @(negedge clk);
      drive(3'd0, 16'h1234, 8'hEE);
      check(can_insert == 1'b0, "R3 can_insert low in interval", can_insert, 0);
      check(in_taken == 1'b0, "R3 no take in interval", in_taken, 0);
      @(negedge clk);
      drive(3'd0, 16'h1234, 8'hB2);
      check(can_insert == 1'b1, "R3 can_insert back", can_insert, 1);
      check(in_taken == 1'b1, "R3 second take", in_taken, 1);
      idle_step();
      check(cyc == k0 + 3 && out_valid && out_tag == 8'hA1, "R11 first out", out_tag, 8'hA1);
      @(negedge clk); #1;
      check(out_valid == 1'b0, "R11 bubble gap", out_valid, 0);
      @(negedge clk); #1;
      check(out_valid && out_tag == 8'hB2, "R11 second out", out_tag, 8'hB2);
    end

    // Tail stall with a queued token (R4, R5)
    repeat (6) @(negedge clk);
    out_accept = 1'b0;
    #1;
    drive(3'd0, 16'h1234, 8'hC1);
    idle_step();
    @(negedge clk);
    drive(3'd0, 16'h1234, 8'hC2);
    check(in_taken == 1'b1, "R4 queued take", in_taken, 1);
    idle_step();
    check(out_valid && out_tag == 8'hC1, "R4 head presented", out_tag, 8'hC1);
    @(negedge clk);
    drive(3'd0, 16'h1234, 8'hC3);
    check(can_insert == 1'b0, "R5 stage 0 occupied", can_insert, 0);
    check(in_taken == 1'b0, "R5 no take while frozen", in_taken, 0);
    idle_step();
    check(out_valid && out_tag == 8'hC1, "R4 head held", out_tag, 8'hC1);
    out_accept = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R4 next not yet at tail", out_valid, 0);
    @(negedge clk); #1;
    check(out_valid && out_tag == 8'hC2, "R4 order kept", out_tag, 8'hC2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule